// File: doc/BRIEF.md
# GCR Sync-Framed Read/Write Path

This block sits behind a bit-cell recovery front end on a disk-style serial channel. In read mode it shifts each recovered bit into a 10-bit window. It detects a sync mark, which is a run of ten 1 bits, and counts the bits that follow so that the window can be split into 10-bit group-coded words. A combinational code table turns a 10-bit window into two 4-bit nibbles and a validity flag. A window that holds any 5-bit group outside the 16-entry 4-to-5 code is flagged as invalid.

In write mode the same table works in the other direction. The 8-bit parallel input, together with a mode bit, selects either the 10-bit encoding of the byte or an all-ones sync mark. On the write-shift strobe that closes each 10-bit frame, the table word is loaded into a 10-bit write register. That register then shifts left once per write-shift strobe, and its MSB is presented as the serial write bit on each sample strobe.

The front end supplies two strobes, sample and shift, which are never expected to fall in the same cycle. All status outputs are active low and registered.

Top module: `gcr_frame_path`

## Requirements
- R1: On each cycle with `sample_i` high, `bit_i` enters bit 0 of a 10-bit read window, earlier bits move up one place, and the bit leaving bit 9 is dropped.
- R2: `sync_n_o` is low in the cycle after an edge exactly when `rd_mode_i` was high at that edge and the read window, after any shift at that edge, is all ones. Otherwise it is high.
- R3: A bit counter is forced to 0 at any edge where the sync condition holds. At other edges where `sample_i` is high and `sync_n_o` was already high, it counts 0 to 9 and then wraps to 0.
- R4: In read mode the table is addressed by {1, window}. `lut_o[13:12]` is 0. `lut_o[11:8]` is the nibble decoded from window bits 9:5, and `lut_o[7:4]` is the nibble decoded from bits 4:0. `lut_o[3]` is 1 only if both 5-bit groups are legal codes, and `lut_o[2:0]` is 0. The code for nibbles 0 through F is 0A,0B,12,13,0E,0F,16,17,09,19,1A,1B,0D,1D,1E,15 (hex).
- R5: In write mode the table is addressed by {0, 0, data[7:4], mode, data[3:0]}. With `mode_i`=1, `lut_o[13:4]` is {code(data[7:4]), code(data[3:0])}. With `mode_i`=0, it is 10'h3FF. In both cases `lut_o[3]`=1 and `lut_o[2:0]`=0.
- R6: `ready_n_o` is low for the one cycle after an edge where `shift_i` was high and the bit counter was 9. At that edge the write register loads `lut_o[13:4]` as produced for that edge.
- R7: At other edges where `shift_i` is high, the write register shifts left and a 0 fills bit 0. At an edge where `sample_i` is high in write mode, `wr_bit_o` takes the register's bit 9 from before the edge. At other write-mode edges `wr_bit_o` holds its value, and in read mode it is 0.
- R8: `error_n_o` is low exactly when the table word registered at that edge has bit 3 equal to 0 and `ready_n_o` is high.
- R9: While reset is held, the outputs are `sync_n_o`=1, `ready_n_o`=1, `error_n_o`=1, `lut_o`=0 and `wr_bit_o`=0. The read window, the bit counter and the write register are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Strobe: recovered bit is valid |
| shift_i | input | 1 | Strobe: advance the write register |
| bit_i | input | 1 | Recovered data bit |
| rd_mode_i | input | 1 | 1 = read, 0 = write |
| mode_i | input | 1 | Write mode: 1 = encode data, 0 = sync mark |
| data_i | input | 8 | Parallel byte to encode |
| sync_n_o | output | 1 | Active-low sync found |
| ready_n_o | output | 1 | Active-low frame boundary / write load |
| error_n_o | output | 1 | Active-low invalid code |
| lut_o | output | 14 | Registered code table word |
| wr_bit_o | output | 1 | Serial write bit |

## Verification
Directed read patterns are used first. A long run of ones shows that sync asserts on the tenth 1 and holds after it, and a single 0 releases it. A known legal word after sync separates correct decoding from window-order mistakes, and the all-zero window after reset exercises the invalid-code path. Directed write patterns with encoded data and with the sync mark check the load point and the order in which the serialised bits leave. Constrained-random strobes and bits follow, with read runs biased toward long strings of ones and periodic mode switches. These cover counter wrap, sync dropping in mid-frame, and writes that span a mode change.

// File: rtl/gcr_frame_pkg.sv
package gcr_frame_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  function automatic logic [SYM_W-1:0] gcr_enc(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] c;
    case (n)
      4'h0: c = 5'h0A;
      4'h1: c = 5'h0B;
      4'h2: c = 5'h12;
      4'h3: c = 5'h13;
      4'h4: c = 5'h0E;
      4'h5: c = 5'h0F;
      4'h6: c = 5'h16;
      4'h7: c = 5'h17;
      4'h8: c = 5'h09;
      4'h9: c = 5'h19;
      4'hA: c = 5'h1A;
      4'hB: c = 5'h1B;
      4'hC: c = 5'h0D;
      4'hD: c = 5'h1D;
      4'hE: c = 5'h1E;
      default: c = 5'h15;
    endcase
    return c;
  endfunction

  // returns {legal, nibble}
  function automatic logic [NIB_W:0] gcr_dec(input logic [SYM_W-1:0] c);
    logic [NIB_W:0] r;
    case (c)
      5'h0A: r = 5'h10;
      5'h0B: r = 5'h11;
      5'h12: r = 5'h12;
      5'h13: r = 5'h13;
      5'h0E: r = 5'h14;
      5'h0F: r = 5'h15;
      5'h16: r = 5'h16;
      5'h17: r = 5'h17;
      5'h09: r = 5'h18;
      5'h19: r = 5'h19;
      5'h1A: r = 5'h1A;
      5'h1B: r = 5'h1B;
      5'h0D: r = 5'h1C;
      5'h1D: r = 5'h1D;
      5'h1E: r = 5'h1E;
      5'h15: r = 5'h1F;
      default: r = 5'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gcr_read_framer.sv
module gcr_read_framer #(
  parameter int WORD_W  = 10,
  parameter int CNT_MOD = 10,
  localparam int CNT_W  = $clog2(CNT_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] win_nxt_o,
  output logic              sync_now_o,
  output logic              sync_n_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MOD - 1);

  logic [WORD_W-1:0] win_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sync_n_q;

  assign win_nxt_o  = sample_i ? {win_q[WORD_W-2:0], bit_i} : win_q;
  assign sync_now_o = rd_i && (win_nxt_o == {WORD_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q    <= '0;
      cnt_q    <= '0;
      sync_n_q <= 1'b1;
    end else begin
      win_q    <= win_nxt_o;
      sync_n_q <= ~sync_now_o;
      if (sync_now_o)
        cnt_q <= '0;
      else if (sample_i && sync_n_q)
        cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign sync_n_o = sync_n_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/gcr_code_rom.sv
module gcr_code_rom
  import gcr_frame_pkg::*;
#(
  parameter int NSYM = 2,
  localparam int WORD_W = NSYM * SYM_W,
  localparam int DATA_W = NSYM * NIB_W,
  localparam int IDX_W  = WORD_W + 1,
  localparam int TBL_W  = WORD_W + 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [TBL_W-1:0] word_o
);
  logic              rd_sel;
  logic              mode_bit;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rd_nib;
  logic [NSYM-1:0]   rd_ok;
  logic [WORD_W-1:0] enc_word;

  assign rd_sel   = idx_i[IDX_W-1];
  assign mode_bit = idx_i[NIB_W];
  assign wdata    = {idx_i[DATA_W:NIB_W+1], idx_i[NIB_W-1:0]};

  for (genvar g = 0; g < NSYM; g++) begin : g_sym
    logic [NIB_W:0] dec;
    assign dec = gcr_dec(idx_i[g*SYM_W +: SYM_W]);
    assign rd_nib[g*NIB_W +: NIB_W]     = dec[NIB_W-1:0];
    assign rd_ok[g]                     = dec[NIB_W];
    assign enc_word[g*SYM_W +: SYM_W]   = gcr_enc(wdata[g*NIB_W +: NIB_W]);
  end

  always_comb begin
    if (rd_sel)
      word_o = {{(WORD_W-DATA_W){1'b0}}, rd_nib, &rd_ok, 3'b000};
    else if (mode_bit)
      word_o = {enc_word, 1'b1, 3'b000};
    else
      word_o = {{WORD_W{1'b1}}, 1'b1, 3'b000};
  end
endmodule

// File: rtl/gcr_write_shifter.sv
module gcr_write_shifter #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              rd_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              wr_bit_o
);
  logic [WORD_W-1:0] sr_q;
  logic              wbit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      wbit_q <= 1'b0;
    end else begin
      if (load_i)
        sr_q <= word_i;
      else if (shift_i)
        sr_q <= {sr_q[WORD_W-2:0], 1'b0};
      if (rd_i)
        wbit_q <= 1'b0;
      else if (sample_i)
        wbit_q <= sr_q[WORD_W-1];
    end
  end

  assign wr_bit_o = wbit_q;
endmodule

// File: rtl/gcr_frame_path.sv
module gcr_frame_path
  import gcr_frame_pkg::*;
#(
  parameter int NSYM    = 2,
  parameter int CNT_MOD = 10,
  localparam int WORD_W = NSYM * SYM_W,
  localparam int DATA_W = NSYM * NIB_W,
  localparam int IDX_W  = WORD_W + 1,
  localparam int TBL_W  = WORD_W + 4,
  localparam int CNT_W  = $clog2(CNT_MOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              rd_mode_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sync_n_o,
  output logic              ready_n_o,
  output logic              error_n_o,
  output logic [TBL_W-1:0]  lut_o,
  output logic              wr_bit_o
);
  localparam int PAD_W = IDX_W - DATA_W - 2;

  logic [WORD_W-1:0] win_nxt;
  logic              sync_now;
  logic [CNT_W-1:0]  cnt_w;
  logic [IDX_W-1:0]  idx;
  logic [TBL_W-1:0]  tbl_nxt;
  logic              load_now;
  logic              ready_n_q;
  logic              error_n_q;
  logic [TBL_W-1:0]  lut_q;

  gcr_read_framer #(.WORD_W(WORD_W), .CNT_MOD(CNT_MOD)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample_i),
    .bit_i     (bit_i),
    .rd_i      (rd_mode_i),
    .win_nxt_o (win_nxt),
    .sync_now_o(sync_now),
    .sync_n_o  (sync_n_o),
    .cnt_o     (cnt_w)
  );

  always_comb begin
    if (rd_mode_i)
      idx = {1'b1, win_nxt};
    else
      idx = {1'b0, {PAD_W{1'b0}}, data_i[DATA_W-1:NIB_W], mode_i, data_i[NIB_W-1:0]};
  end

  gcr_code_rom #(.NSYM(NSYM)) u_rom (
    .idx_i (idx),
    .word_o(tbl_nxt)
  );

  assign load_now = shift_i && (cnt_w == CNT_W'(CNT_MOD - 1));

  gcr_write_shifter #(.WORD_W(WORD_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_now),
    .shift_i (shift_i),
    .sample_i(sample_i),
    .rd_i    (rd_mode_i),
    .word_i  (tbl_nxt[TBL_W-1:4]),
    .wr_bit_o(wr_bit_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_n_q <= 1'b1;
      error_n_q <= 1'b1;
      lut_q     <= '0;
    end else begin
      ready_n_q <= ~load_now;
      error_n_q <= ~(~tbl_nxt[3] & ~load_now);
      lut_q     <= tbl_nxt;
    end
  end

  assign ready_n_o = ready_n_q;
  assign error_n_o = error_n_q;
  assign lut_o     = lut_q;
endmodule

// File: rtl/gcr_frame_path_chk.sv
module gcr_frame_path_chk #(
  parameter int CNT_MOD = 10,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_i,
  input logic             shift_i,
  input logic             rd_mode_i,
  input logic             sync_n_o,
  input logic             ready_n_o,
  input logic             error_n_o,
  input logic             wr_bit_o,
  input logic [CNT_W-1:0] cnt_w
);
  // R2
  sync_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> $past(rd_mode_i));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w < CNT_W'(CNT_MOD));

  // R3
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_o |-> (cnt_w == '0));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_n_o |-> $past(shift_i));

  // R8
  err_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !error_n_o |-> ready_n_o);

  // R7
  wbit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_mode_i) |-> !wr_bit_o);

  // R7
  wbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sample_i) && !$past(rd_mode_i)) |-> $stable(wr_bit_o));
endmodule

bind gcr_frame_path gcr_frame_path_chk #(.CNT_MOD(CNT_MOD), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample_i (sample_i),
  .shift_i  (shift_i),
  .rd_mode_i(rd_mode_i),
  .sync_n_o (sync_n_o),
  .ready_n_o(ready_n_o),
  .error_n_o(error_n_o),
  .wr_bit_o (wr_bit_o),
  .cnt_w    (cnt_w)
);

// File: tb/gcr_frame_path_test.sv
module gcr_frame_path_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0, shift_i = 1'b0, bit_i = 1'b0;
  logic       rd_mode_i = 1'b1, mode_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       sync_n_o, ready_n_o, error_n_o, wr_bit_o;
  logic [13:0] lut_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gcr_frame_path uut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .shift_i(shift_i),
    .bit_i(bit_i), .rd_mode_i(rd_mode_i), .mode_i(mode_i), .data_i(data_i),
    .sync_n_o(sync_n_o), .ready_n_o(ready_n_o), .error_n_o(error_n_o),
    .lut_o(lut_o), .wr_bit_o(wr_bit_o)
  );

  // bench reference state
  logic [9:0] m_win = '0;
  logic [9:0] m_wsr = '0;
  int         m_cnt = 0;
  bit         m_sync = 0;
  logic       m_wbit = 1'b0;

  function automatic logic [4:0] code_of(input logic [3:0] n);
    logic [4:0] t [16] = '{5'h0A, 5'h0B, 5'h12, 5'h13, 5'h0E, 5'h0F, 5'h16, 5'h17,
                           5'h09, 5'h19, 5'h1A, 5'h1B, 5'h0D, 5'h1D, 5'h1E, 5'h15};
    return t[n];
  endfunction

  function automatic logic [4:0] nib_of(input logic [4:0] c);
    for (int k = 0; k < 16; k++)
      if (code_of(4'(k)) == c) return {1'b1, 4'(k)};
    return 5'h00;
  endfunction

  function automatic logic [13:0] exp_lut(input logic rd, input logic [9:0] w,
                                          input logic md, input logic [7:0] d);
    logic [4:0] a, b;
    if (rd) begin
      a = nib_of(w[9:5]);
      b = nib_of(w[4:0]);
      return {2'b00, a[3:0], b[3:0], a[4] & b[4], 3'b000};
    end
    if (md) return {code_of(d[7:4]), code_of(d[3:0]), 1'b1, 3'b000};
    return {10'h3FF, 1'b1, 3'b000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare at next negedge
  task automatic step(input bit smp, input bit shf, input bit b, input bit rd,
                      input bit md, input logic [7:0] d);
    logic [9:0]  win_n;
    logic [13:0] tbl;
    bit          syn, ld;
    sample_i = smp; shift_i = shf; bit_i = b; rd_mode_i = rd; mode_i = md; data_i = d;
    win_n = smp ? {m_win[8:0], b} : m_win;
    syn   = rd && (win_n == 10'h3FF);
    ld    = shf && (m_cnt == 9);
    tbl   = exp_lut(rd, win_n, md, d);
    if (syn) m_cnt = 0;
    else if (smp && !m_sync) m_cnt = (m_cnt == 9) ? 0 : m_cnt + 1;
    if (rd) m_wbit = 1'b0;
    else if (smp) m_wbit = m_wsr[9];
    if (ld) m_wsr = tbl[13:4];
    else if (shf) m_wsr = {m_wsr[8:0], 1'b0};
    m_win  = win_n;
    m_sync = syn;
    @(negedge clk);
    check(sync_n_o == !syn, "R2", sync_n_o, !syn);
    check(ready_n_o == !ld, "R3/R6", ready_n_o, !ld);
    check(lut_o == tbl, rd ? "R1/R4" : "R5", lut_o, tbl);
    check(error_n_o == !(!tbl[3] && !ld), "R8", error_n_o, !(!tbl[3] && !ld));
    check(wr_bit_o == m_wbit, "R7", wr_bit_o, m_wbit);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    check(sync_n_o == 1'b1, "R9", sync_n_o, 1);
    check(ready_n_o == 1'b1, "R9", ready_n_o, 1);
    check(error_n_o == 1'b1, "R9", error_n_o, 1);
    check(lut_o == '0, "R9", lut_o, 0);
    check(wr_bit_o == 1'b0, "R9", wr_bit_o, 0);
    rst_n = 1'b1;

    // R2: ten ones make sync, extra ones keep it, a zero drops it
    for (int i = 0; i < 14; i++) step(1, 0, 1, 1, 0, 8'h00);
    step(0, 1, 0, 1, 0, 8'h00);
    step(1, 0, 0, 1, 0, 8'h00);
    // R1/R4: word for 0xA5 after sync, then an illegal word (R8)
    for (int i = 9; i >= 0; i--) begin
      step(1, 0, ((10'h34F >> i) & 1) != 0, 1, 0, 8'h00);
      step(0, 1, 0, 1, 0, 8'h00);
    end
    for (int i = 0; i < 10; i++) begin
      step(1, 0, 0, 1, 0, 8'h00);
      step(0, 1, 0, 1, 0, 8'h00);
    end

    // R5/R6/R7: encoded write data, then a sync mark
    for (int i = 0; i < 30; i++) begin
      step(1, 0, 0, 0, 1, 8'h3C);
      step(0, 1, 0, 0, 1, 8'h3C);
    end
    for (int i = 0; i < 30; i++) begin
      step(1, 0, 0, 0, 0, 8'h96);
      step(0, 1, 0, 0, 0, 8'h96);
    end

    // random mix, runs of ones biased in read mode
    begin
      bit rd = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        int r;
        if (i % 250 == 0) rd = $urandom_range(0, 1);
        r = $urandom_range(0, 3);
        step(r == 1, r == 2, rd ? ($urandom_range(0, 9) < 8) : $urandom_range(0, 1),
             rd, $urandom_range(0, 1), 8'($urandom));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule